// File: doc/BRIEF.md
# Decade Counter with Seven-Segment Output

This block is a synchronous divide-by-ten counter whose count lives in a five-bit Johnson (twisted-ring) register instead of a binary value. The ring pattern is decoded into the digits 0 to 9 and then into active-high drive for a seven-segment display. A display-enable input blanks the segments without disturbing the count. This allows several digits to share display power or to be strobed in turn.

Two outputs ignore the display enable. The carry output is a square wave at one tenth of the clock rate, and it can clock the next decade of a chain directly. The ungated c-segment output stays valid at all times, which makes divide-by-12 and divide-by-60 arrangements possible with a little outside logic. Any ring pattern outside the ten legal codes is forced back into the sequence, so the counter cannot lock up in a parasitic loop.

Top module: `decade_seg_counter`

## Requirements
- R1: While `rst_i` is high, the counter is held at count 0 without waiting for a clock. `seg_o` then shows digit 0 when enabled, and `carry_o` is high.
- R2: On each rising clock edge with `inhibit_i` low and a legal ring, the count moves from n to (n+1) mod 10. The ring codes for counts 0 to 9 are 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000 and 10000.
- R3: While `inhibit_i` is high at a rising edge and the ring is legal, the count does not change.
- R4: A ring pattern that is not one of the ten legal codes becomes count 0 at the next rising edge, whatever the level of `inhibit_i`.
- R5: `carry_o` is high for counts 0 to 4 and low for counts 5 to 9. With the clock uninhibited it therefore has a period of ten clocks, and it rises on the wrap from 9 to 0.
- R6: With display enable high, `seg_o` drives bit 0 = a, bit 1 = b, ..., bit 6 = g, active high. The lit segment sets are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 abcdefg, 9 abcdfg.
- R7: While `disp_en_i` is low, all seven bits of `seg_o` are 0 whatever the count.
- R8: `c_ungated_o` is high for every digit except 2, and neither it nor `carry_o` depends on `disp_en_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Count clock, rising edge |
| rst_i | input | 1 | Asynchronous reset to count 0, active high |
| inhibit_i | input | 1 | High holds the count |
| disp_en_i | input | 1 | High lets the segments light |
| seg_o | output | 7 | Segment drive, bit 0 = a through bit 6 = g |
| carry_o | output | 1 | Divide-by-ten carry for cascading |
| c_ungated_o | output | 1 | Segment c, not affected by display enable |

## Verification
The assertions assume that reset is high from time zero. They also assume that `inhibit_i` and `disp_en_i` change only away from the rising clock edge. The stimulus meets both conditions by driving every input on the falling edge. Illegal ring codes cannot be produced through the ports, so the recovery checks place each of the 22 illegal codes into the ring register at a falling edge and then let one rising edge act on it. The random phases mix inhibit and enable levels with seeded `$urandom`. Directed phases then cover the full carry period, a reset in mid-count, and recovery with inhibit both high and low.

// File: rtl/jdec_pkg.sv
package jdec_pkg;
  localparam int RING_W = 5;
  localparam int SEG_W  = 7;
  localparam int DIGITS = 2 * RING_W;
  localparam int DIG_W  = $clog2(DIGITS);

  typedef logic [RING_W-1:0] ring_t;
  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [DIG_W-1:0]  digit_t;

  // Legal codes are low-filled thermometers (msb 0) or their complements (msb 1).
  function automatic logic ring_legal(ring_t r);
    ring_t t;
    t = r[RING_W-1] ? ~r : r;
    return (t & (t + ring_t'(1))) == '0;
  endfunction

  // Twisted shift for legal codes; anything else collapses to count 0.
  function automatic ring_t ring_next(ring_t r);
    if (ring_legal(r)) return {r[RING_W-2:0], ~r[RING_W-1]};
    return '0;
  endfunction

  function automatic digit_t ring_to_digit(ring_t r);
    int ones;
    ones = 0;
    for (int i = 0; i < RING_W; i++) ones += int'(r[i]);
    if (r[RING_W-1]) return digit_t'(DIGITS - ones);
    return digit_t'(ones);
  endfunction

  // Bit 0 = a ... bit 6 = g, active high.
  function automatic seg_t digit_to_seg(digit_t d);
    case (d)
      4'd0:    return 7'h3F;
      4'd1:    return 7'h06;
      4'd2:    return 7'h5B;
      4'd3:    return 7'h4F;
      4'd4:    return 7'h66;
      4'd5:    return 7'h6D;
      4'd6:    return 7'h7D;
      4'd7:    return 7'h07;
      4'd8:    return 7'h7F;
      4'd9:    return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/jdec_ring.sv
module jdec_ring
  import jdec_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  inhibit_i,
  output ring_t ring_o,
  output logic  legal_o
);
  ring_t ring_q;
  logic  legal_w;
  logic  step_w;

  assign legal_w = ring_legal(ring_q);
  // Recovery ignores inhibit so an illegal code never persists.
  assign step_w  = !inhibit_i || !legal_w;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)       ring_q <= '0;
    else if (step_w) ring_q <= ring_next(ring_q);
  end

  assign ring_o  = ring_q;
  assign legal_o = legal_w;

  AST_RESET_ZERO: assert property (@(posedge clk_i) rst_i |-> ring_q == '0); // R1
  AST_ADVANCE_MOVES: assert property (@(posedge clk_i) disable iff (rst_i)
    (!inhibit_i && legal_w) |=> ring_q != $past(ring_q)); // R2
  AST_HOLD_INHIBIT: assert property (@(posedge clk_i) disable iff (rst_i)
    (inhibit_i && legal_w) |=> $stable(ring_q)); // R3
  AST_RECOVER_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !legal_w |=> ring_q == '0); // R4
endmodule

// File: rtl/jdec_decode.sv
module jdec_decode
  import jdec_pkg::*;
(
  input  ring_t  ring_i,
  output digit_t digit_o,
  output seg_t   seg_raw_o
);
  assign digit_o   = ring_to_digit(ring_i);
  assign seg_raw_o = digit_to_seg(digit_o);
endmodule

// File: rtl/jdec_gate.sv
module jdec_gate
  import jdec_pkg::*;
(
  input  seg_t seg_raw_i,
  input  logic disp_en_i,
  output seg_t seg_o,
  output logic c_ungated_o
);
  localparam int C_BIT = 2;
  assign seg_o       = disp_en_i ? seg_raw_i : '0;
  assign c_ungated_o = seg_raw_i[C_BIT];
endmodule

// File: rtl/decade_seg_counter.sv
module decade_seg_counter
  import jdec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             inhibit_i,
  input  logic             disp_en_i,
  output logic [SEG_W-1:0] seg_o,
  output logic             carry_o,
  output logic             c_ungated_o
);
  ring_t  ring_w;
  logic   legal_w;
  digit_t digit_w;
  seg_t   seg_raw_w;

  jdec_ring u_ring (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .inhibit_i (inhibit_i),
    .ring_o    (ring_w),
    .legal_o   (legal_w)
  );

  jdec_decode u_dec (
    .ring_i    (ring_w),
    .digit_o   (digit_w),
    .seg_raw_o (seg_raw_w)
  );

  jdec_gate u_gate (
    .seg_raw_i   (seg_raw_w),
    .disp_en_i   (disp_en_i),
    .seg_o       (seg_o),
    .c_ungated_o (c_ungated_o)
  );

  // High for the first half of the decade: straight from the ring's top bit.
  assign carry_o = ~ring_w[RING_W-1];

  AST_CARRY_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(carry_o) |-> digit_w == '0); // R5
  AST_DIGIT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    legal_w |-> int'(digit_w) < DIGITS); // R6
  AST_BLANK_SEG: assert property (@(posedge clk_i) disable iff (rst_i)
    !disp_en_i |-> seg_o == '0 && seg_raw_w != '0 || !legal_w); // R7
  AST_C_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
    disp_en_i |-> seg_o[2] == c_ungated_o); // R8
endmodule

// File: tb/decade_seg_counter_test.sv
module decade_seg_counter_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inh = 1'b0;
  logic       en  = 1'b1;
  logic [6:0] seg;
  logic       carry;
  logic       c_ung;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_cnt = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decade_seg_counter uut (
    .clk_i(clk), .rst_i(rst), .inhibit_i(inh), .disp_en_i(en),
    .seg_o(seg), .carry_o(carry), .c_ungated_o(c_ung)
  );

  function automatic logic [6:0] model_seg(int d);
    logic [6:0] s;
    s[0] = !(d == 1 || d == 4);
    s[1] = !(d == 5 || d == 6);
    s[2] = (d != 2);
    s[3] = !(d == 1 || d == 4 || d == 7);
    s[4] = (d == 0 || d == 2 || d == 6 || d == 8);
    s[5] = !(d == 1 || d == 2 || d == 3 || d == 7);
    s[6] = !(d == 0 || d == 1 || d == 7);
    return s;
  endfunction

  function automatic bit model_legal(int p);
    for (int k = 0; k <= 5; k++) begin
      if (p == (1 << k) - 1) return 1'b1;
      if (p == (31 ^ ((1 << k) - 1))) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic check_outputs(string req);
    logic [6:0] es;
    es = en ? model_seg(exp_cnt) : 7'h00;
    check(seg == es, req, "seg_o", int'(seg), int'(es));
    check(carry == (exp_cnt < 5), "R5", "carry_o", int'(carry), int'(exp_cnt < 5));
    check(c_ung == (exp_cnt != 2), "R8", "c_ungated_o", int'(c_ung), int'(exp_cnt != 2));
  endtask

  // Drive at the falling edge, let one rising edge act, check at the next falling edge.
  task automatic step(bit i_inh, bit i_en, string req);
    inh = i_inh;
    en  = i_en;
    @(posedge clk);
    if (!i_inh) exp_cnt = (exp_cnt + 1) % 10;
    @(negedge clk);
    check_outputs(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int last_rise;
    int cyc;
    logic prev_c;
    void'($urandom(32'd4026));

    // R1 reset state
    @(negedge clk);
    @(negedge clk);
    exp_cnt = 0;
    check_outputs("R1");
    rst = 1'b0;

    // R2 and R6: walk all ten digits twice with the display on
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, (i % 2) ? "R6" : "R2");

    // R7: blanked display while counting
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, "R7");

    // R3: hold under inhibit, display on and off
    for (int i = 0; i < 6; i++) step(1'b1, i[0], "R3");

    // R5: carry period of ten and rising edge at wrap
    while (exp_cnt != 9) step(1'b0, 1'b1, "R5");
    last_rise = -1;
    prev_c = carry;
    for (cyc = 0; cyc < 40; cyc++) begin
      step(1'b0, 1'b1, "R5");
      if (carry && !prev_c) begin
        check(exp_cnt == 0, "R5", "count at carry rise", exp_cnt, 0);
        if (last_rise >= 0)
          check(cyc - last_rise == 10, "R5", "carry period", cyc - last_rise, 10);
        last_rise = cyc;
      end
      prev_c = carry;
    end

    // Random mix of inhibit and enable
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) == 0, ($urandom % 3) != 0, "R8");

    // R1: reset mid-count acts without a clock edge
    while (exp_cnt == 0) step(1'b0, 1'b1, "R2");
    #1 rst = 1'b1;
    #1;
    exp_cnt = 0;
    check_outputs("R1");
    @(negedge clk);
    check_outputs("R1");
    rst = 1'b0;

    // R4: every illegal code recovers to count 0, inhibit high and low
    for (int p = 0; p < 32; p++) begin
      if (!model_legal(p)) begin
        for (int h = 0; h < 2; h++) begin
          force uut.u_ring.ring_q = 5'(p);
          #1 release uut.u_ring.ring_q;
          inh = h[0];
          en  = 1'b1;
          @(posedge clk);
          exp_cnt = 0;
          @(negedge clk);
          check_outputs("R4");
          step(1'b0, 1'b1, "R4");
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule